// File: doc/BRIEF.md
# Byte-Lane Data Access Alignment Unit

This unit sits between a processor's load/store path and a 32-bit data memory organised as four byte-wide lanes that share one long-word address decode and have separate write enables. For each access it takes an effective address, an access size (byte, word or long word) and a write flag. It drives the long-word address, the per-lane write strobes and the lane-steered write data. On a read it picks the addressed byte or halfword out of the returned 32-bit word, right-justifies it and optionally sign-extends it. It also produces the pointer value after a post-increment, scaled by the access size.

A second read-only port serves the wide-operand path and accepts only word and long-word sizes. On either port a misaligned access is not blocked: it completes with a deterministic lane choice and raises an address error. The error is held in a sticky pending-trap register until an external controller acknowledges it, which lets that controller take the trap one instruction later.

Top module: `lane_align_unit`

## Requirements
- R1: Size code 2'b00 is byte, 2'b01 is word, 2'b10 is long word, and 2'b11 is handled exactly as long word. On both ports the memory address is effective address bits [AW-1:2].
- R2: A primary-port read returns, little-endian, the byte at offset ea[1:0] (offset 0 is bits [7:0]) or the halfword selected by ea[1] (ea[1]=1 is bits [31:16]) in the low bits of the result. A long-word read returns the whole word.
- R3: The write strobes are zero unless a primary-port write is requested. A byte write sets only strobe bit ea[1:0]. A word write sets strobes 4'b0011 when ea[1]=0 and 4'b1100 when ea[1]=1, with ea[0] ignored. A long-word write sets 4'b1111.
- R4: Write data is placed on the strobed lanes: the low byte is shifted left by 8*ea[1:0], the low halfword by 16*ea[1], and a long word is passed unchanged. Unstrobed lanes carry zero.
- R5: A word access with ea[0]=1, or a long-word access with ea[1:0]!=0, is misaligned. It still completes, with its strobes asserted, and the pending-trap output is 1 in the cycle after it is requested.
- R6: The pending trap stays set until the acknowledge input is high at a clock edge. A new error in that same cycle wins over the acknowledge. Synchronous reset clears the pending trap.
- R7: The next-address output equals ea + 1 for byte, ea + 2 for word and ea + 4 for long-word accesses, with wrap-around at 2^AW.
- R8: With the sign-extend input at 1, a byte result copies bit 7 into bits [31:8] and a word result copies bit 15 into bits [31:16]. With it at 0 those upper bits are zero.
- R9: The second port returns a zero-extended halfword selected by ea[1], or a whole long word. A byte request on it is illegal: it sets the pending trap and is served as a word access with a step of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_req | input | 1 | Primary port access request |
| x_we | input | 1 | Primary port write (1) or read (0) |
| x_size | input | 2 | Primary access size code |
| x_sext | input | 1 | Sign-extend the primary read result |
| x_ea | input | AW | Primary effective byte address |
| x_wdata | input | 32 | Primary write data, right-justified |
| x_mem_addr | output | AW-2 | Primary long-word memory address |
| x_mem_be | output | 4 | Per-lane write strobes |
| x_mem_wdata | output | 32 | Lane-steered write data |
| x_mem_rdata | input | 32 | Word returned by memory for the primary port |
| x_rdata | output | 32 | Right-justified, extended read result |
| x_next_ea | output | AW | Post-incremented primary address |
| y_req | input | 1 | Second port read request |
| y_size | input | 2 | Second port size code |
| y_ea | input | AW | Second port effective byte address |
| y_mem_addr | output | AW-2 | Second port long-word memory address |
| y_mem_rdata | input | 32 | Word returned by memory for the second port |
| y_rdata | output | 32 | Second port read result |
| y_next_ea | output | AW | Post-incremented second port address |
| trap_ack | input | 1 | Clears the pending address-error trap |
| trap_pend | output | 1 | Sticky address-error trap request |

## Verification
The hardest case to reach from the ports is a new address error that arrives in the same cycle as the acknowledge of an earlier one. The bench first leaves a trap pending, then drives a misaligned access with the acknowledge raised, and checks that the trap survives. The stimulus also covers the illegal byte request on the second port and every size code against every byte offset, with both write and read and both extension settings, so that each misaligned combination is seen to complete with its strobes still asserted.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    localparam int LANES   = 4;
    localparam int DATA_W  = 32;
    localparam int OFF_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        acc_size_e        sz;
        logic [OFF_W-1:0] off;
    } acc_t;

    // Reserved code maps to long; on the wide-only port byte maps to word.
    function automatic acc_size_e norm_size(logic [1:0] raw, bit wide_only);
        acc_size_e s;
        s = acc_size_e'(raw);
        if (s == SZ_RSVD)
            s = SZ_LONG;
        else if (wide_only && s == SZ_BYTE)
            s = SZ_WORD;
        return s;
    endfunction

    function automatic logic is_misaligned(acc_size_e s, logic [OFF_W-1:0] off);
        case (s)
            SZ_WORD: is_misaligned = off[0];
            SZ_LONG: is_misaligned = |off;
            default: is_misaligned = 1'b0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(acc_size_e s, logic [OFF_W-1:0] off);
        case (s)
            SZ_BYTE: lane_mask = LANES'(1) << off;
            SZ_WORD: lane_mask = off[1] ? 4'b1100 : 4'b0011;
            default: lane_mask = {LANES{1'b1}};
        endcase
    endfunction

    function automatic logic [2:0] size_step(acc_size_e s);
        case (s)
            SZ_BYTE: size_step = 3'd1;
            SZ_WORD: size_step = 3'd2;
            default: size_step = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/la_addr_gen.sv
module la_addr_gen
    import lane_align_pkg::*;
#(
    parameter int AW        = 32,
    parameter bit WIDE_ONLY = 1'b0
) (
    input  logic [AW-1:0] ea,
    input  logic [1:0]    size_raw,
    output acc_t          acc,
    output logic          err,
    output logic [AW-1:0] next_ea
);

    acc_size_e sz_n;
    logic      illegal_size;

    generate
        if (WIDE_ONLY) begin : g_wide
            assign illegal_size = (size_raw == 2'b00);
        end else begin : g_full
            assign illegal_size = 1'b0;
        end
    endgenerate

    always_comb begin
        sz_n    = norm_size(size_raw, WIDE_ONLY);
        acc.sz  = sz_n;
        acc.off = ea[OFF_W-1:0];
        err     = is_misaligned(sz_n, ea[OFF_W-1:0]) | illegal_size;
        next_ea = ea + AW'(size_step(sz_n));
    end

endmodule

// File: rtl/la_rd_steer.sv
module la_rd_steer
    import lane_align_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  acc_t              acc,
    input  logic              sext,
    output logic [DATA_W-1:0] value
);

    logic [DATA_W-1:0] shifted;

    always_comb begin
        case (acc.sz)
            SZ_BYTE: begin
                shifted = rdata >> {acc.off, 3'b000};
                value   = {{24{sext & shifted[7]}}, shifted[7:0]};
            end
            SZ_WORD: begin
                shifted = rdata >> {acc.off[1], 4'b0000};
                value   = {{16{sext & shifted[15]}}, shifted[15:0]};
            end
            default: begin
                shifted = rdata;
                value   = shifted;
            end
        endcase
    end

endmodule

// File: rtl/la_wr_steer.sv
module la_wr_steer
    import lane_align_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  acc_t              acc,
    input  logic              wr_en,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_data
);

    always_comb begin
        be = wr_en ? lane_mask(acc.sz, acc.off) : '0;
        case (acc.sz)
            SZ_BYTE: lane_data = {24'b0, wdata[7:0]}  << {acc.off, 3'b000};
            SZ_WORD: lane_data = {16'b0, wdata[15:0]} << {acc.off[1], 4'b0000};
            default: lane_data = wdata;
        endcase
    end

endmodule

// File: rtl/la_trap_reg.sv
module la_trap_reg (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
        else if (ack)
            pend <= 1'b0;
    end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
    import lane_align_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              x_req,
    input  logic              x_we,
    input  logic [1:0]        x_size,
    input  logic              x_sext,
    input  logic [AW-1:0]     x_ea,
    input  logic [31:0]       x_wdata,
    output logic [AW-3:0]     x_mem_addr,
    output logic [3:0]        x_mem_be,
    output logic [31:0]       x_mem_wdata,
    input  logic [31:0]       x_mem_rdata,
    output logic [31:0]       x_rdata,
    output logic [AW-1:0]     x_next_ea,
    input  logic              y_req,
    input  logic [1:0]        y_size,
    input  logic [AW-1:0]     y_ea,
    output logic [AW-3:0]     y_mem_addr,
    input  logic [31:0]       y_mem_rdata,
    output logic [31:0]       y_rdata,
    output logic [AW-1:0]     y_next_ea,
    input  logic              trap_ack,
    output logic              trap_pend
);

    localparam int WA = AW - OFF_W;

    acc_t x_acc, y_acc;
    logic x_err, y_err;
    logic err_event;

    la_addr_gen #(.AW(AW), .WIDE_ONLY(1'b0)) u_x_addr (
        .ea       (x_ea),
        .size_raw (x_size),
        .acc      (x_acc),
        .err      (x_err),
        .next_ea  (x_next_ea)
    );

    la_addr_gen #(.AW(AW), .WIDE_ONLY(1'b1)) u_y_addr (
        .ea       (y_ea),
        .size_raw (y_size),
        .acc      (y_acc),
        .err      (y_err),
        .next_ea  (y_next_ea)
    );

    la_wr_steer u_x_wr (
        .wdata     (x_wdata),
        .acc       (x_acc),
        .wr_en     (x_req & x_we),
        .be        (x_mem_be),
        .lane_data (x_mem_wdata)
    );

    la_rd_steer u_x_rd (
        .rdata (x_mem_rdata),
        .acc   (x_acc),
        .sext  (x_sext),
        .value (x_rdata)
    );

    la_rd_steer u_y_rd (
        .rdata (y_mem_rdata),
        .acc   (y_acc),
        .sext  (1'b0),
        .value (y_rdata)
    );

    assign err_event = (x_req & x_err) | (y_req & y_err);

    la_trap_reg u_trap (
        .clk  (clk),
        .rst  (rst),
        .set  (err_event),
        .ack  (trap_ack),
        .pend (trap_pend)
    );

    assign x_mem_addr = x_ea[AW-1:OFF_W];
    assign y_mem_addr = y_ea[AW-1:OFF_W];

    // WA documents the word-address width; tie it to the port width.
    initial begin
        if (WA != AW - 2) $display("lane_align_unit: unexpected lane count");
    end

endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          x_req,
    input logic          x_we,
    input logic [1:0]    x_size,
    input logic [AW-1:0] x_ea,
    input logic [3:0]    x_mem_be,
    input logic [AW-1:0] x_next_ea,
    input logic          y_req,
    input logic [1:0]    y_size,
    input logic [AW-1:0] y_ea,
    input logic          trap_ack,
    input logic          trap_pend
);

    logic x_bad, y_bad, any_bad;
    logic [AW-1:0] x_delta;

    always_comb begin
        x_bad = x_req && ((x_size == 2'b01 && x_ea[0]) ||
                          (x_size[1] && x_ea[1:0] != 2'b00));
        y_bad = y_req && ((y_size == 2'b00) ||
                          (y_size == 2'b01 && y_ea[0]) ||
                          (y_size[1] && y_ea[1:0] != 2'b00));
        any_bad = x_bad || y_bad;
        x_delta = x_next_ea - x_ea;
    end

    p_no_strobe_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !(x_req && x_we) |-> x_mem_be == 4'b0000);

    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
        (x_req && x_we && x_size == 2'b00) |-> $countones(x_mem_be) == 1);

    p_word_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (x_req && x_we && x_size == 2'b01) |-> (x_mem_be == 4'b0011 || x_mem_be == 4'b1100));

    p_bad_write_completes_r5: assert property (@(posedge clk) disable iff (rst)
        (x_bad && x_we) |-> x_mem_be != 4'b0000);

    p_trap_raise_r5: assert property (@(posedge clk) disable iff (rst)
        x_bad |=> trap_pend);

    p_trap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (trap_pend && !trap_ack) |=> trap_pend);

    p_trap_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (trap_ack && !any_bad) |=> !trap_pend);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (!trap_pend && !any_bad) |=> !trap_pend);

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        x_delta == AW'(1) || x_delta == AW'(2) || x_delta == AW'(4));

    p_y_byte_trap_r9: assert property (@(posedge clk) disable iff (rst)
        (y_req && y_size == 2'b00) |=> trap_pend);

endmodule

bind lane_align_unit lane_align_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .x_req     (x_req),
    .x_we      (x_we),
    .x_size    (x_size),
    .x_ea      (x_ea),
    .x_mem_be  (x_mem_be),
    .x_next_ea (x_next_ea),
    .y_req     (y_req),
    .y_size    (y_size),
    .y_ea      (y_ea),
    .trap_ack  (trap_ack),
    .trap_pend (trap_pend)
);

// File: tb/lane_align_unit_test.sv
module lane_align_unit_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          x_req = 0, x_we = 0, x_sext = 0;
    logic [1:0]    x_size = 0;
    logic [AW-1:0] x_ea = 0;
    logic [31:0]   x_wdata = 0, x_mem_rdata = 0;
    logic [AW-3:0] x_mem_addr;
    logic [3:0]    x_mem_be;
    logic [31:0]   x_mem_wdata, x_rdata;
    logic [AW-1:0] x_next_ea;
    logic          y_req = 0;
    logic [1:0]    y_size = 0;
    logic [AW-1:0] y_ea = 0;
    logic [AW-3:0] y_mem_addr;
    logic [31:0]   y_mem_rdata = 0, y_rdata;
    logic [AW-1:0] y_next_ea;
    logic          trap_ack = 0;
    logic          trap_pend;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lane_align_unit #(.AW(AW)) uut (
        .clk(clk), .rst(rst),
        .x_req(x_req), .x_we(x_we), .x_size(x_size), .x_sext(x_sext),
        .x_ea(x_ea), .x_wdata(x_wdata), .x_mem_addr(x_mem_addr),
        .x_mem_be(x_mem_be), .x_mem_wdata(x_mem_wdata),
        .x_mem_rdata(x_mem_rdata), .x_rdata(x_rdata), .x_next_ea(x_next_ea),
        .y_req(y_req), .y_size(y_size), .y_ea(y_ea), .y_mem_addr(y_mem_addr),
        .y_mem_rdata(y_mem_rdata), .y_rdata(y_rdata), .y_next_ea(y_next_ea),
        .trap_ack(trap_ack), .trap_pend(trap_pend)
    );

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic clear_trap();
        @(negedge clk);
        x_req = 0; y_req = 0; trap_ack = 1;
        @(posedge clk); #1;
        check("R6", "trap cleared by ack", {31'b0, trap_pend}, 32'd0);
        @(negedge clk);
        trap_ack = 0;
    endtask

    task automatic x_access(int sz, int off, bit we, bit sx, logic [31:0] wd,
                            logic [31:0] rd, logic [29:0] base);
        int esz, expect_be;
        bit bad;
        logic [31:0] ea, exp_wd, exp_rd, v;
        esz = (sz == 3) ? 2 : sz;
        ea  = {base, 2'(off)};
        bad = (esz == 1 && (off % 2) == 1) || (esz == 2 && off != 0);
        if (!we)           expect_be = 0;
        else if (esz == 0) expect_be = 1 << off;
        else if (esz == 1) expect_be = (off < 2) ? 3 : 12;
        else               expect_be = 15;
        if (esz == 0)      exp_wd = (wd % 256) << (8 * off);
        else if (esz == 1) exp_wd = (wd % 65536) << (16 * (off / 2));
        else               exp_wd = wd;
        if (esz == 0) begin
            v = (rd >> (8 * off)) % 256;
            if (sx && v >= 128) v = v + 32'hFFFF_FF00;
        end else if (esz == 1) begin
            v = (rd >> (16 * (off / 2))) % 65536;
            if (sx && v >= 32768) v = v + 32'hFFFF_0000;
        end else begin
            v = rd;
        end
        exp_rd = v;

        @(negedge clk);
        x_req = 1; x_we = we; x_size = 2'(sz); x_sext = sx;
        x_ea = ea; x_wdata = wd; x_mem_rdata = rd;
        #1;
        check("R1", "memory address", {2'b00, x_mem_addr}, ea / 4);
        check("R3", "write strobes", {28'b0, x_mem_be}, 32'(expect_be));
        if (we) check("R4", "steered write data", x_mem_wdata, exp_wd);
        if (sx) check("R8", "sign-extended read", x_rdata, exp_rd);
        else    check("R2", "read select", x_rdata, exp_rd);
        check("R7", "post-increment", x_next_ea, ea + (1 << esz));
        if (bad && we) check("R5", "misaligned write still strobes",
                             {31'b0, x_mem_be != 0}, 32'd1);
        @(posedge clk); #1;
        check("R5", "trap after access", {31'b0, trap_pend}, {31'b0, bad});
        @(negedge clk);
        x_req = 0; x_we = 0;
        if (bad) clear_trap();
    endtask

    task automatic y_access(int sz, int off, logic [31:0] rd, logic [29:0] base);
        int esz;
        bit bad;
        logic [31:0] ea, exp_rd;
        esz = (sz == 3) ? 2 : ((sz == 0) ? 1 : sz);
        ea  = {base, 2'(off)};
        bad = (sz == 0) || (esz == 1 && (off % 2) == 1) || (esz == 2 && off != 0);
        exp_rd = (esz == 1) ? (rd >> (16 * (off / 2))) % 65536 : rd;
        @(negedge clk);
        y_req = 1; y_size = 2'(sz); y_ea = ea; y_mem_rdata = rd;
        #1;
        check("R1", "second port address", {2'b00, y_mem_addr}, ea / 4);
        check("R9", "second port read", y_rdata, exp_rd);
        check("R9", "second port increment", y_next_ea, ea + (1 << esz));
        @(posedge clk); #1;
        check("R9", "second port trap", {31'b0, trap_pend}, {31'b0, bad});
        @(negedge clk);
        y_req = 0;
        if (bad) clear_trap();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R6", "reset clears trap", {31'b0, trap_pend}, 32'd0);
        check("R3", "no strobes at reset", {28'b0, x_mem_be}, 32'd0);
        @(negedge clk);
        rst = 0;

        for (int p = 0; p < 2; p++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int off = 0; off < 4; off++) begin
                    for (int we = 0; we < 2; we++) begin
                        for (int sx = 0; sx < 2; sx++) begin
                            logic [31:0] rd, wd;
                            rd = (p == 0) ? 32'h8C7F_E401 : 32'h0F80_7E93;
                            rd = rd ^ (32'(off) * 32'h1111_0000);
                            wd = 32'hA5C3_96F1 + 32'(sz * 16 + off * 4 + we * 2 + sx);
                            x_access(sz, off, we[0], sx[0], wd, rd,
                                     30'(p * 32'h1357_9BDF + sz * 7 + off));
                        end
                    end
                end
            end
        end

        x_access(2, 0, 0, 0, 32'h0, 32'h1234_5678, 30'h3FFF_FFFF);

        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 4; off++) begin
                y_access(sz, off, 32'hF00D_8765 ^ 32'(sz * 4 + off), 30'(sz * 33 + off));
            end
        end

        @(negedge clk);
        x_req = 1; x_we = 0; x_size = 2'b10; x_ea = 32'h0000_0102;
        @(posedge clk); #1;
        check("R5", "long misaligned raises trap", {31'b0, trap_pend}, 32'd1);
        @(negedge clk);
        x_req = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R6", "trap held without ack", {31'b0, trap_pend}, 32'd1);
        @(negedge clk);
        x_req = 1; x_size = 2'b01; x_ea = 32'h0000_0203; trap_ack = 1;
        @(posedge clk); #1;
        check("R6", "new error wins over ack", {31'b0, trap_pend}, 32'd1);
        @(negedge clk);
        x_ea = 32'h0000_0204;
        @(posedge clk); #1;
        check("R6", "ack with aligned access clears", {31'b0, trap_pend}, 32'd0);
        @(negedge clk);
        x_req = 0; trap_ack = 0;
        y_req = 1; y_size = 2'b00; y_ea = 32'h0000_0010;
        @(posedge clk); #1;
        check("R9", "byte on second port traps", {31'b0, trap_pend}, 32'd1);
        @(negedge clk);
        y_req = 0;
        rst = 1;
        @(posedge clk); #1;
        check("R6", "reset clears pending trap", {31'b0, trap_pend}, 32'd0);
        @(negedge clk);
        rst = 0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule